// File: doc/BRIEF.md
# Parallel MIDI Host Port

This block sits between a host microprocessor and a synthesizer core. The host reaches it over an 8-bit parallel bus with an active-low chip select, separate active-low read and write strobes, and a single register-select line. With the select line low, the host moves MIDI bytes in and out. With it high, a read returns a status byte and a write sends a command. Write bytes are taken when the write strobe returns high. A data read is taken as consumed when the read strobe returns high.

The block has two routing modes. After reset it is in synth mode: bytes from the serial MIDI receiver go straight to the synthesizer core. A UART-mode command sends those bytes instead into a one-byte holding register that the host reads. A reset command brings the port back to synth mode. Both commands leave an acknowledge byte in the holding register. An interrupt line stays high while the holding register has a byte the host has not read. In UART mode, host data writes go out on a byte strobe to a serial transmitter.

All strobe inputs are taken to be already synchronous to `clk`. The bus is split into an input, an output and an output enable, which an I/O pad combines into a tri-state pin.

Top module: `midi_host_port`

## Requirements
- R1: After reset the port is in synth mode, `irq` is 0, the holding register is empty and no output strobe is active.
- R2: `d_oe` is 1 only while `cs_n` and `rd_n` are both 0. During such a read, `d_out` carries the holding register when `a0`=0 and the status byte when `a0`=1.
- R3: The status byte has bit 7 = NOT `tx_ready`, bit 6 = 0 exactly when a byte is waiting in the holding register, and bits 5..0 all 1.
- R4: In synth mode, a `midi_valid` pulse produces `synth_valid`=1 in the next cycle with `synth_byte` equal to the input byte. The holding register is untouched.
- R5: When the write strobe rises with `cs_n`=0 and `a0`=1, command 0x3F given in synth mode switches to UART mode. It also loads 0xFE into the holding register, so `irq` goes to 1.
- R6: In UART mode a received MIDI byte goes into the holding register, and `synth_valid` stays 0.
- R7: A rising read strobe with `cs_n`=0 and `a0`=0 empties the holding register and drops `irq`. A status read leaves both unchanged.
- R8: While the holding register is full, further received MIDI bytes are dropped, and the held byte is kept.
- R9: Command 0xFF, given in either mode, returns the port to synth mode and replaces the holding register with 0xFE.
- R10: A data write (`a0`=0) in UART mode produces a one-cycle `tx_valid` with `tx_byte` equal to the written byte. In synth mode it has no effect.
- R11: Any other command byte, and 0x3F while already in UART mode, is ignored. No acknowledge is produced and the mode does not change.
- R12: Write strobes with `cs_n`=1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Register select: 0 data, 1 status/command |
| d_in | input | 8 | Bus data from host |
| d_out | output | 8 | Bus data to host |
| d_oe | output | 1 | Bus output enable |
| irq | output | 1 | Byte-available interrupt, active high |
| midi_valid | input | 1 | Serial receiver byte strobe |
| midi_byte | input | 8 | Serial receiver byte |
| synth_valid | output | 1 | Byte strobe to synthesizer core |
| synth_byte | output | 8 | Byte to synthesizer core |
| tx_ready | input | 1 | Serial transmitter can take a byte |
| tx_valid | output | 1 | Byte strobe to serial transmitter |
| tx_byte | output | 8 | Byte to serial transmitter |

## Verification
The hardest state to reach is a full holding register in UART mode that receives a new MIDI byte or a repeated UART command. The bench first has to issue a command, then leave the acknowledge byte unread, before the drop and ignore rules can be seen. Directed sequences set up exactly that order. Random sequences then mix commands, unread bytes and partial reads, so that acknowledge bytes and MIDI bytes compete for the single slot in many different orders.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CMD_RESET = BYTE_W'(8'hFF);
    localparam byte_t CMD_UART  = BYTE_W'(8'h3F);
    localparam byte_t ACK_BYTE  = BYTE_W'(8'hFE);

    typedef enum logic {
        MODE_SYNTH = 1'b0,
        MODE_UART  = 1'b1
    } route_mode_e;

    typedef struct packed {
        logic  wr_data;
        logic  wr_ctrl;
        logic  rd_data;
        byte_t wbyte;
    } host_ev_t;

    function automatic byte_t status_word(input logic tx_ready, input logic rx_full);
        byte_t s;
        s = '1;
        s[BYTE_W-1] = ~tx_ready;
        s[BYTE_W-2] = ~rx_full;
        return s;
    endfunction
endpackage

// File: rtl/midi_host_strobe.sv
module midi_host_strobe
    import midi_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     rd_n,
    input  logic     wr_n,
    input  logic     a0,
    input  byte_t    d_in,
    output host_ev_t ev
);
    logic  cs_q, rd_q, wr_q, a0_q;
    byte_t d_q;
    logic  wr_rise, rd_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b1;
            rd_q <= 1'b1;
            wr_q <= 1'b1;
            a0_q <= 1'b0;
            d_q  <= '0;
        end else begin
            cs_q <= cs_n;
            rd_q <= rd_n;
            wr_q <= wr_n;
            a0_q <= a0;
            d_q  <= d_in;
        end
    end

    // Strobe end detected against the selects seen while it was low
    assign wr_rise = !wr_q && wr_n && !cs_q;
    assign rd_rise = !rd_q && rd_n && !cs_q;

    always_comb begin
        ev.wr_data = wr_rise && !a0_q;
        ev.wr_ctrl = wr_rise &&  a0_q;
        ev.rd_data = rd_rise && !a0_q;
        ev.wbyte   = d_q;
    end
endmodule

// File: rtl/midi_mode_ctrl.sv
module midi_mode_ctrl
    import midi_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  host_ev_t    ev,
    output route_mode_e mode,
    output logic        ack_load,
    output logic        tx_valid,
    output byte_t       tx_byte
);
    logic is_reset_cmd, is_uart_cmd;

    assign is_reset_cmd = ev.wr_ctrl && (ev.wbyte == CMD_RESET);
    assign is_uart_cmd  = ev.wr_ctrl && (ev.wbyte == CMD_UART) && (mode == MODE_SYNTH);
    assign ack_load     = is_reset_cmd || is_uart_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_SYNTH;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            if (is_reset_cmd)
                mode <= MODE_SYNTH;
            else if (is_uart_cmd)
                mode <= MODE_UART;
            tx_valid <= ev.wr_data && (mode == MODE_UART);
            if (ev.wr_data && (mode == MODE_UART))
                tx_byte <= ev.wbyte;
        end
    end
endmodule

// File: rtl/midi_rx_hold.sv
module midi_rx_hold
    import midi_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ack_load,
    input  route_mode_e mode,
    input  logic        midi_valid,
    input  byte_t       midi_byte,
    input  logic        rd_ack,
    output byte_t       rx_data,
    output logic        rx_full
);
    logic take_midi;

    assign take_midi = (mode == MODE_UART) && midi_valid && (!rx_full || rd_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (ack_load) begin
            rx_data <= ACK_BYTE;
            rx_full <= 1'b1;
        end else if (take_midi) begin
            rx_data <= midi_byte;
            rx_full <= 1'b1;
        end else if (rd_ack) begin
            rx_full <= 1'b0;
        end
    end
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
    import midi_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        a0,
    input  logic [7:0]  d_in,
    output logic [7:0]  d_out,
    output logic        d_oe,
    output logic        irq,
    input  logic        midi_valid,
    input  logic [7:0]  midi_byte,
    output logic        synth_valid,
    output logic [7:0]  synth_byte,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_byte
);
    host_ev_t    ev;
    route_mode_e mode;
    logic        ack_load;
    logic        rd_ack;
    byte_t       rx_data;
    logic        rx_full;

    midi_host_strobe u_strobe (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .d_in(d_in), .ev(ev)
    );

    midi_mode_ctrl u_mode (
        .clk(clk), .rst(rst), .ev(ev), .mode(mode), .ack_load(ack_load),
        .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    assign rd_ack = ev.rd_data;

    midi_rx_hold u_hold (
        .clk(clk), .rst(rst), .ack_load(ack_load), .mode(mode),
        .midi_valid(midi_valid), .midi_byte(midi_byte), .rd_ack(rd_ack),
        .rx_data(rx_data), .rx_full(rx_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            synth_valid <= 1'b0;
            synth_byte  <= '0;
        end else begin
            synth_valid <= midi_valid && (mode == MODE_SYNTH);
            if (midi_valid && (mode == MODE_SYNTH))
                synth_byte <= midi_byte;
        end
    end

    assign irq   = rx_full;
    assign d_oe  = !cs_n && !rd_n;
    assign d_out = a0 ? status_word(tx_ready, rx_full) : rx_data;
endmodule

// File: rtl/midi_host_port_chk.sv
module midi_host_port_chk
    import midi_port_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        midi_valid,
    input byte_t       midi_byte,
    input logic        synth_valid,
    input byte_t       synth_byte,
    input route_mode_e mode,
    input logic        tx_valid,
    input logic        irq,
    input logic        rd_ack,
    input logic        ack_load,
    input logic        rx_full,
    input byte_t       rx_data
);
    // R4
    synth_route_chk: assert property (@(posedge clk) disable iff (rst)
        (midi_valid && mode == MODE_SYNTH) |=> (synth_valid && synth_byte == $past(midi_byte)));

    // R6
    uart_block_chk: assert property (@(posedge clk) disable iff (rst)
        (midi_valid && mode == MODE_UART) |=> !synth_valid);

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(rd_ack));

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rd_ack && !ack_load) |=> (rx_full && $stable(rx_data)));

    // R10
    tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> !tx_valid);

    // R5
    ack_irq_chk: assert property (@(posedge clk) disable iff (rst)
        ack_load |=> (irq && rx_data == ACK_BYTE));
endmodule

bind midi_host_port midi_host_port_chk u_chk (
    .clk(clk), .rst(rst), .midi_valid(midi_valid), .midi_byte(midi_byte),
    .synth_valid(synth_valid), .synth_byte(synth_byte), .mode(mode),
    .tx_valid(tx_valid), .irq(irq), .rd_ack(rd_ack), .ack_load(ack_load),
    .rx_full(rx_full), .rx_data(rx_data)
);

// File: tb/midi_host_port_bench.sv
module midi_host_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] d_in = 8'h00;
    logic [7:0] d_out;
    logic       d_oe, irq;
    logic       midi_valid = 1'b0;
    logic [7:0] midi_byte = 8'h00;
    logic       synth_valid;
    logic [7:0] synth_byte;
    logic       tx_ready = 1'b1;
    logic       tx_valid;
    logic [7:0] tx_byte;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model
    logic       m_uart = 1'b0;
    logic       m_full = 1'b0;
    logic [7:0] m_data = 8'h00;

    logic       got_v;
    logic [7:0] got_b;

    always #4 clk = ~clk;

    midi_host_port u_midi_host_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .irq(irq),
        .midi_valid(midi_valid), .midi_byte(midi_byte),
        .synth_valid(synth_valid), .synth_byte(synth_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    function automatic logic [7:0] exp_status(input logic rdy, input logic full);
        return {~rdy, ~full, 6'h3F};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic av, input logic [7:0] b);
        @(negedge clk);
        cs_n = !sel; a0 = av; d_in = b; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        got_v = tx_valid; got_b = tx_byte;
        cs_n = 1'b1; d_in = 8'($urandom);
    endtask

    task automatic do_read(input logic av);
        @(negedge clk);
        cs_n = 1'b0; a0 = av; rd_n = 1'b0;
        @(negedge clk);
        got_v = d_oe; got_b = d_out;
        rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic do_midi(input logic [7:0] b);
        @(negedge clk);
        midi_valid = 1'b1; midi_byte = b;
        @(negedge clk);
        got_v = synth_valid; got_b = synth_byte;
        midi_valid = 1'b0;
    endtask

    // model-driven operations with checks
    task automatic op_midi(input logic [7:0] b);
        do_midi(b);
        if (!m_uart) begin
            check(got_v == 1'b1 && got_b == b, "R4", {got_v, got_b}, {1'b1, b});
        end else begin
            check(got_v == 1'b0, "R6", got_v, 0);
            if (!m_full) begin m_full = 1'b1; m_data = b; end
        end
        check(irq == m_full, m_uart ? "R8" : "R4", irq, m_full);
    endtask

    task automatic op_ctrl(input logic [7:0] c);
        do_write(1'b1, 1'b1, c);
        check(got_v == 1'b0, "R11", got_v, 0);
        if (c == 8'hFF) begin
            m_uart = 1'b0; m_full = 1'b1; m_data = 8'hFE;
        end else if (c == 8'h3F && !m_uart) begin
            m_uart = 1'b1; m_full = 1'b1; m_data = 8'hFE;
        end
        check(irq == m_full, (c == 8'hFF) ? "R9" : "R5", irq, m_full);
    endtask

    task automatic op_wdata(input logic [7:0] b);
        do_write(1'b1, 1'b0, b);
        if (m_uart)
            check(got_v == 1'b1 && got_b == b, "R10", {got_v, got_b}, {1'b1, b});
        else
            check(got_v == 1'b0, "R10", got_v, 0);
        check(irq == m_full, "R10", irq, m_full);
    endtask

    task automatic op_rdata();
        do_read(1'b0);
        check(got_v == 1'b1 && got_b == m_data, "R2", {got_v, got_b}, {1'b1, m_data});
        m_full = 1'b0;
        check(irq == 1'b0, "R7", irq, 0);
        check(d_oe == 1'b0, "R2", d_oe, 0);
    endtask

    task automatic op_rstat();
        do_read(1'b1);
        check(got_v == 1'b1 && got_b == exp_status(tx_ready, m_full), "R3",
              got_b, exp_status(tx_ready, m_full));
        check(irq == m_full, "R7", irq, m_full);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2193));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(irq == 1'b0, "R1", irq, 0);
        check(synth_valid == 1'b0 && tx_valid == 1'b0, "R1", {synth_valid, tx_valid}, 0);
        check(d_oe == 1'b0, "R2", d_oe, 0);
        op_rstat();
        // R1/R4 synth routing after reset
        op_midi(8'h90);
        op_midi(8'h3C);
        // R10 data write in synth mode ignored
        op_wdata(8'h55);
        // R11 unknown command ignored
        op_ctrl(8'h12);
        op_midi(8'h40);
        // R5 enter UART mode
        op_ctrl(8'h3F);
        tx_ready = 1'b0;
        op_rstat();
        tx_ready = 1'b1;
        // R8 ack unread, MIDI byte dropped
        op_midi(8'hA1);
        // R11 repeat UART cmd ignored while in UART mode
        op_ctrl(8'h3F);
        op_rdata();
        op_rstat();
        // R6 byte captured, second dropped
        op_midi(8'h77);
        op_midi(8'h78);
        op_rstat();
        op_rdata();
        // R10 transmit in UART mode
        op_wdata(8'hC3);
        // R12 writes with chip select high ignored
        do_write(1'b0, 1'b1, 8'hFF);
        check(got_v == 1'b0 && irq == 1'b0, "R12", {got_v, irq}, 0);
        op_midi(8'h11);
        check(got_v == 1'b0, "R12", got_v, 0);
        op_rdata();
        // R9 reset command from UART mode
        op_ctrl(8'hFF);
        op_midi(8'h22);
        op_rdata();

        // random mix
        for (int i = 0; i < 500; i++) begin
            int k;
            k = $urandom_range(0, 9);
            tx_ready = 1'($urandom);
            case (k)
                0, 1:    op_midi(8'($urandom));
                2:       op_ctrl(8'hFF);
                3:       op_ctrl(8'h3F);
                4:       op_ctrl(8'($urandom));
                5, 6:    op_wdata(8'($urandom));
                7:       op_rdata();
                default: op_rstat();
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule